// File: doc/BRIEF.md
# Streaming Port Get/Put Unit

This unit connects a processor execute stage to a bank of outgoing and incoming streaming ports. The number of ports in each direction is a parameter and defaults to sixteen. The execute stage issues one request at a time, and each request is either a get or a put. A request picks its port in one of two ways: from an immediate field, or at run time from the low bits of a register operand. It also says whether it moves a data word or a control word, and whether it blocks.

Every port uses a valid/ready handshake with a sideband tag bit beside the data word. The tag is 0 for a data word and 1 for a control word. A blocking request holds the execute stage through a combinational stall until its port can complete the transfer. A non-blocking request never stalls, and it reports whether it succeeded through a carry flag update.

A get that receives a word whose tag does not match the requested kind raises a stream-error flag update. The read data and all flag updates come out of a register one cycle after the transfer completes. A register-file writeback stage can use them directly.

Top module: `stream_xfer_unit`

## Requirements
- R1: The port index comes from the low log2(NPORT) bits of `req_reg_port` when `req_dyn`=1, and from `req_imm_port` when `req_dyn`=0. The other bits of `req_reg_port` are ignored.
- R2: A blocking get (`req_nb`=0, `req_put`=0) drives `stall` high in the same cycle while the selected port's `in_tvalid` is 0. It drives `stall` low once that bit is 1.
- R3: A blocking put drives `stall` high in the same cycle while the selected port's `out_tready` is 0.
- R4: A non-blocking request (`req_nb`=1) never drives `stall` high.
- R5: In the cycle after a non-blocking get, `carry_upd` is 1 and `carry` equals the inverse of the selected port's `in_tvalid`. After a blocking request or an idle cycle, both are 0.
- R6: In the cycle after a non-blocking put, `carry_upd` is 1 and `carry` equals the inverse of the selected port's `out_tready`, which is the full indication.
- R7: A non-blocking get that finds no valid word transfers nothing. In the next cycle `rd_valid` is 0 and `err_set` is 0.
- R8: In the cycle after a completed get, `err_set` is 1 in two cases: a data get (`req_ctrl`=0) received tag 1, or a control get received tag 0. Otherwise `err_set` is 0.
- R9: A put raises `out_tvalid` only on the selected port. It drives that port's `out_tlast` to `req_ctrl` (0 for data, 1 for control) and its `out_tdata` to `req_wdata`.
- R10: A get raises `in_tready` only on the selected port. No unselected port sees `in_tready` or `out_tvalid`.
- R11: In the cycle after a get completes (valid and ready both high), `rd_valid` is 1 and `rd_data` holds the received word.
- R12: While `rst_n` is low, `rd_valid`, `carry_upd`, `carry` and `err_set` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A request is present this cycle |
| req_put | input | 1 | 1 = put (write), 0 = get (read) |
| req_ctrl | input | 1 | 1 = control word, 0 = data word |
| req_nb | input | 1 | 1 = non-blocking, 0 = blocking |
| req_dyn | input | 1 | 1 = port from register operand, 0 = from immediate |
| req_imm_port | input | PW | Static port index |
| req_reg_port | input | DW | Register operand whose low PW bits give the dynamic port |
| req_wdata | input | DW | Word to put |
| stall | output | 1 | Holds the execute stage this cycle |
| rd_valid | output | 1 | A get completed last cycle |
| rd_data | output | DW | Word received by the last completed get |
| carry_upd | output | 1 | Carry flag is to be written |
| carry | output | 1 | New carry value |
| err_set | output | 1 | Stream-error flag is to be set |
| out_tvalid | output | NPORT | Per-port valid of outgoing ports |
| out_tready | input | NPORT | Per-port ready of outgoing ports |
| out_tdata | output | NPORT*DW | Outgoing data, port i at bits i*DW |
| out_tlast | output | NPORT | Outgoing control tag |
| in_tvalid | input | NPORT | Per-port valid of incoming ports |
| in_tready | output | NPORT | Per-port ready of incoming ports |
| in_tdata | input | NPORT*DW | Incoming data, port i at bits i*DW |
| in_tlast | input | NPORT | Incoming control tag |

## Verification
On every cycle, the assertions check four things:
- A non-blocking request never stalls.
- At most one outgoing valid and one incoming ready are high.
- A carry update always follows a non-blocking request.
- A stream-error report only comes with a completed get.

Only the bench scenarios can show the actual values: the port chosen by each addressing form, the carry polarity for gets and puts, the data and tag of each word, and the mismatch error for each tag combination. The bench compares these against a model of the port handshake.

// File: rtl/sxu_pkg.sv
package sxu_pkg;
  localparam int unsigned NPORT_DEF = 16;
  localparam int unsigned DW_DEF    = 32;

  typedef enum logic {
    DIR_GET = 1'b0,
    DIR_PUT = 1'b1
  } sxu_dir_e;
endpackage

// File: rtl/sxu_port_sel.sv
module sxu_port_sel #(
  parameter int unsigned DW = 32,
  parameter int unsigned PW = 4
) (
  input  logic          dyn,
  input  logic [PW-1:0] imm_port,
  input  logic [DW-1:0] reg_op,
  output logic [PW-1:0] port
);
  logic unused_hi;
  assign unused_hi = ^reg_op[DW-1:PW];

  always_comb begin
    if (dyn) port = reg_op[PW-1:0];
    else     port = imm_port;
  end
endmodule

// File: rtl/sxu_out_demux.sv
module sxu_out_demux #(
  parameter int unsigned NPORT = 16,
  parameter int unsigned DW    = 32,
  parameter int unsigned PW    = 4
) (
  input  logic [PW-1:0]       port,
  input  logic                put_en,
  input  logic                ctrl,
  input  logic [DW-1:0]       wdata,
  input  logic [NPORT-1:0]    out_tready,
  output logic [NPORT-1:0]    out_tvalid,
  output logic [NPORT*DW-1:0] out_tdata,
  output logic [NPORT-1:0]    out_tlast,
  output logic                ready_sel
);
  for (genvar i = 0; i < NPORT; i++) begin : g_out
    logic hit;
    assign hit                 = (port == PW'(i));
    assign out_tvalid[i]       = put_en & hit;
    assign out_tlast[i]        = ctrl & hit;
    assign out_tdata[i*DW +: DW] = wdata;
  end

  assign ready_sel = out_tready[port];
endmodule

// File: rtl/sxu_in_mux.sv
module sxu_in_mux #(
  parameter int unsigned NPORT = 16,
  parameter int unsigned DW    = 32,
  parameter int unsigned PW    = 4
) (
  input  logic [PW-1:0]       port,
  input  logic                get_en,
  input  logic [NPORT-1:0]    in_tvalid,
  input  logic [NPORT*DW-1:0] in_tdata,
  input  logic [NPORT-1:0]    in_tlast,
  output logic [NPORT-1:0]    in_tready,
  output logic                valid_sel,
  output logic [DW-1:0]       data_sel,
  output logic                last_sel
);
  for (genvar i = 0; i < NPORT; i++) begin : g_in
    assign in_tready[i] = get_en & (port == PW'(i));
  end

  assign valid_sel = in_tvalid[port];
  assign last_sel  = in_tlast[port];
  assign data_sel  = in_tdata[port*DW +: DW];
endmodule

// File: rtl/sxu_result_reg.sv
module sxu_result_reg #(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          get_fire,
  input  logic [DW-1:0] get_data,
  input  logic          tag_mismatch,
  input  logic          nb_req,
  input  logic          carry_now,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic          carry_upd,
  output logic          carry,
  output logic          err_set
);
  logic          rd_valid_d, carry_upd_d, carry_d, err_set_d;
  logic          data_en;

  always_comb begin
    rd_valid_d  = get_fire;
    data_en     = get_fire;
    carry_upd_d = nb_req;
    carry_d     = nb_req & carry_now;
    err_set_d   = get_fire & tag_mismatch;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid  <= 1'b0;
      carry_upd <= 1'b0;
      carry     <= 1'b0;
      err_set   <= 1'b0;
    end else begin
      rd_valid  <= rd_valid_d;
      carry_upd <= carry_upd_d;
      carry     <= carry_d;
      err_set   <= err_set_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rd_data <= '0;
    else if (data_en) rd_data <= get_data;
  end

  p_err_with_get_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err_set |-> rd_valid);
endmodule

// File: rtl/stream_xfer_unit.sv
module stream_xfer_unit #(
  parameter int unsigned NPORT = sxu_pkg::NPORT_DEF,
  parameter int unsigned DW    = sxu_pkg::DW_DEF,
  localparam int unsigned PW   = (NPORT > 1) ? $clog2(NPORT) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic                req_put,
  input  logic                req_ctrl,
  input  logic                req_nb,
  input  logic                req_dyn,
  input  logic [PW-1:0]       req_imm_port,
  input  logic [DW-1:0]       req_reg_port,
  input  logic [DW-1:0]       req_wdata,
  output logic                stall,
  output logic                rd_valid,
  output logic [DW-1:0]       rd_data,
  output logic                carry_upd,
  output logic                carry,
  output logic                err_set,
  output logic [NPORT-1:0]    out_tvalid,
  input  logic [NPORT-1:0]    out_tready,
  output logic [NPORT*DW-1:0] out_tdata,
  output logic [NPORT-1:0]    out_tlast,
  input  logic [NPORT-1:0]    in_tvalid,
  output logic [NPORT-1:0]    in_tready,
  input  logic [NPORT*DW-1:0] in_tdata,
  input  logic [NPORT-1:0]    in_tlast
);
  import sxu_pkg::*;

  logic [PW-1:0] port;
  logic          put_en, get_en;
  logic          out_rdy_sel, in_vld_sel, in_last_sel;
  logic [DW-1:0] in_data_sel;
  logic          get_fire, carry_now, nb_req;

  sxu_port_sel #(.DW(DW), .PW(PW)) u_sel (
    .dyn(req_dyn), .imm_port(req_imm_port), .reg_op(req_reg_port), .port(port)
  );

  assign put_en = req_valid & (sxu_dir_e'(req_put) == DIR_PUT);
  assign get_en = req_valid & (sxu_dir_e'(req_put) == DIR_GET);

  sxu_out_demux #(.NPORT(NPORT), .DW(DW), .PW(PW)) u_out (
    .port(port), .put_en(put_en), .ctrl(req_ctrl), .wdata(req_wdata),
    .out_tready(out_tready), .out_tvalid(out_tvalid), .out_tdata(out_tdata),
    .out_tlast(out_tlast), .ready_sel(out_rdy_sel)
  );

  sxu_in_mux #(.NPORT(NPORT), .DW(DW), .PW(PW)) u_in (
    .port(port), .get_en(get_en), .in_tvalid(in_tvalid), .in_tdata(in_tdata),
    .in_tlast(in_tlast), .in_tready(in_tready), .valid_sel(in_vld_sel),
    .data_sel(in_data_sel), .last_sel(in_last_sel)
  );

  always_comb begin
    carry_now = req_put ? ~out_rdy_sel : ~in_vld_sel;
    stall     = req_valid & ~req_nb & carry_now;
    get_fire  = get_en & in_vld_sel;
    nb_req    = req_valid & req_nb;
  end

  sxu_result_reg #(.DW(DW)) u_res (
    .clk(clk), .rst_n(rst_n), .get_fire(get_fire), .get_data(in_data_sel),
    .tag_mismatch(in_last_sel ^ req_ctrl), .nb_req(nb_req), .carry_now(carry_now),
    .rd_valid(rd_valid), .rd_data(rd_data), .carry_upd(carry_upd),
    .carry(carry), .err_set(err_set)
  );

  p_nb_no_stall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_nb) |-> !stall);
  p_one_out_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(out_tvalid));
  p_one_in_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(in_tready));
  p_carry_after_nb_r5: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_nb |=> carry_upd);
  p_no_carry_blocking_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_nb) |=> !carry_upd && !carry);
endmodule

// File: tb/stream_xfer_unit_tb_top.sv
module stream_xfer_unit_tb_top;
  localparam int NP = 16;
  localparam int DW = 32;
  localparam int PW = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid, req_put, req_ctrl, req_nb, req_dyn;
  logic [PW-1:0] req_imm_port;
  logic [DW-1:0] req_reg_port, req_wdata;
  logic stall, rd_valid, carry_upd, carry, err_set;
  logic [DW-1:0] rd_data;
  logic [NP-1:0] out_tvalid, out_tready, out_tlast, in_tvalid, in_tready, in_tlast;
  logic [NP*DW-1:0] out_tdata, in_tdata;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  stream_xfer_unit dut_i (.*);

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [PW-1:0] pick_port(input logic dyn, input logic [PW-1:0] imm,
                                              input logic [DW-1:0] r);
    return dyn ? r[PW-1:0] : imm;
  endfunction

  function automatic logic exp_stall(input logic v, input logic put, input logic nb,
                                     input logic rdy, input logic vld);
    return v & ~nb & (put ? ~rdy : ~vld);
  endfunction

  // drive one request at negedge, check combinational then registered results
  task automatic apply(input logic v, input logic put, input logic ctl, input logic nb,
                       input logic dyn, input logic [PW-1:0] imm, input logic [DW-1:0] r,
                       input logic [DW-1:0] wd);
    logic [PW-1:0] p;
    logic fire, e_carry;
    logic [DW-1:0] e_data;
    @(negedge clk);
    req_valid = v; req_put = put; req_ctrl = ctl; req_nb = nb; req_dyn = dyn;
    req_imm_port = imm; req_reg_port = r; req_wdata = wd;
    #2;
    p = pick_port(dyn, imm, r);
    chk(nb ? "R4 stall" : (put ? "R3 stall" : "R2 stall"), DW'(stall),
        DW'(exp_stall(v, put, nb, out_tready[p], in_tvalid[p])));
    chk("R10 out_tvalid one-hot (R1 port)", DW'(out_tvalid),
        (v && put) ? DW'(1) << p : '0);
    chk("R10 in_tready one-hot (R1 port)", DW'(in_tready),
        (v && !put) ? DW'(1) << p : '0);
    if (v && put) begin
      chk("R9 out_tlast tag", DW'(out_tlast[p]), DW'(ctl));
      chk("R9 out_tdata", out_tdata[p*DW +: DW], wd);
    end
    fire    = v & ~put & in_tvalid[p];
    e_data  = in_tdata[p*DW +: DW];
    e_carry = put ? ~out_tready[p] : ~in_tvalid[p];
    @(posedge clk);
    #2;
    chk(fire ? "R11 rd_valid" : "R7 rd_valid", DW'(rd_valid), DW'(fire));
    if (fire) chk("R11 rd_data", rd_data, e_data);
    chk(put ? "R6 carry_upd" : "R5 carry_upd", DW'(carry_upd), DW'(v & nb));
    chk(put ? "R6 carry" : "R5 carry", DW'(carry), DW'(v & nb & e_carry));
    chk(fire ? "R8 err_set" : "R7 err_set", DW'(err_set),
        DW'(fire & (in_tlast[p] ^ ctl)));
  endtask

  task automatic rand_ports();
    out_tready = NP'($urandom);
    in_tvalid  = NP'($urandom);
    in_tlast   = NP'($urandom);
    for (int i = 0; i < NP; i++) in_tdata[i*DW +: DW] = $urandom;
  endtask

  initial begin
    void'($urandom(32'd2024));
    rst_n = 1'b0;
    req_valid = 0; req_put = 0; req_ctrl = 0; req_nb = 0; req_dyn = 0;
    req_imm_port = '0; req_reg_port = '0; req_wdata = '0;
    out_tready = '0; in_tvalid = '0; in_tlast = '0; in_tdata = '0;
    repeat (3) @(posedge clk);
    #2;
    chk("R12 reset rd_valid", DW'(rd_valid), '0);
    chk("R12 reset carry_upd", DW'(carry_upd), '0);
    chk("R12 reset carry", DW'(carry), '0);
    chk("R12 reset err_set", DW'(err_set), '0);
    @(negedge clk); rst_n = 1'b1;

    // R2 blocking get on empty port stalls, then completes
    in_tvalid = '0; in_tdata[5*DW +: DW] = 32'hCAFE_0005; in_tlast[5] = 1'b0;
    apply(1, 0, 0, 0, 0, 4'd5, '0, '0);
    in_tvalid[5] = 1'b1;
    apply(1, 0, 0, 0, 0, 4'd5, '0, '0);
    // R7 non-blocking get on empty port: no transfer, carry = 1
    in_tvalid = '0;
    apply(1, 0, 0, 1, 1, 4'd0, 32'hFFFF_FFF9, '0);
    // R1 dynamic port with high bits set; R8 both mismatch kinds
    in_tvalid = 16'h0208; in_tlast = 16'h0008;
    in_tdata[3*DW +: DW] = 32'h1111_0003; in_tdata[9*DW +: DW] = 32'h2222_0009;
    apply(1, 0, 0, 1, 1, 4'd0, 32'hABCD_0003, '0);
    apply(1, 0, 1, 0, 1, 4'd0, 32'h0000_0109, '0);
    apply(1, 0, 1, 0, 0, 4'd3, '0, '0);
    // R3 blocking put to full port, R6 non-blocking put full/not full
    out_tready = '0;
    apply(1, 1, 1, 0, 0, 4'd15, '0, 32'h5A5A_A5A5);
    apply(1, 1, 0, 1, 0, 4'd15, '0, 32'h1234_5678);
    out_tready[15] = 1'b1;
    apply(1, 1, 1, 1, 0, 4'd15, '0, 32'h8765_4321);
    apply(0, 0, 0, 0, 0, 4'd0, '0, '0);

    for (int n = 0; n < 600; n++) begin
      rand_ports();
      apply(($urandom % 4) != 0, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
            PW'($urandom), $urandom, $urandom);
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule